// File: doc/BRIEF.md
# Adaptive Memory-Error Output Corrector

This block sits after a pipelined converter and removes the error that stage memory effects leave in the output code. Each sample brings the signed decision of every calibrated front stage and the raw code of the remaining back end. The corrected code is the raw code plus a weighted sum of the decisions. Each calibrated stage has two weights: one for the decision of the current sample and one for the decision of the sample before it. Only the first `L` stages are handled, since later stages add little error.

A slow, highly linear reference converter digitizes the same input once every M main samples. Its code arrives a fixed `REF_LAT` cycles after the main sample it belongs to and is marked by a strobe. On each strobe the block takes the reference minus the stored corrected code as the error. It then moves every weight by a least-mean-square step of error times that weight's own decision, scaled down by a power-of-two step size. Between strobes the weights hold. A freeze input stops adaptation while correction continues. A read port brings out any weight.

Top module: `lms_memcorr`

## Requirements
- R1: A synchronous reset makes `corr_out` zero and loads the nominal weights: the current-decision weight of stage s becomes 2^(RAW_W+L-2-s) codes, held as that value times 2^FRAC, and every previous-decision weight becomes zero.
- R2: The sample presented at a clock edge appears on `corr_out` after that edge as floor(sum of weight times decision / 2^FRAC) + `raw_in`, using the weights held before the edge. Decisions are two's-complement fields of DW bits, with stage s at `dec_in` bits [s*DW +: DW]. `raw_in` is unsigned.
- R3: The previous-decision weight of stage s multiplies stage s's decision from the preceding sample.
- R4: At an edge with `ref_valid` high and `freeze` low, every weight w becomes w + ((e*d)*2^FRAC) >>> MU_SH, saturated to the signed WW-bit range. Here e is `ref_in` minus the corrected code of the sample presented REF_LAT edges earlier, and d is that sample's decision for that weight.
- R5: At an edge with `ref_valid` low, no weight changes.
- R6: At an edge with `freeze` high, no weight changes, while correction per R2 goes on.
- R7: The corrected code saturates to the signed OUT_W-bit range.
- R8: `wout` shows weight `wsel` within the same cycle. Index 2s selects stage s's current-decision weight and index 2s+1 selects its previous-decision weight.
- R9: When the reference follows a fixed set of weights and the decisions take every value, the adapted weights settle within one code of that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| freeze | input | 1 | Holds the weights when high |
| dec_in | input | L*DW | Signed stage decisions, stage 0 in the low field |
| raw_in | input | RAW_W | Unsigned back-end code |
| ref_in | input | OUT_W | Signed reference code, aligned REF_LAT samples late |
| ref_valid | input | 1 | Marks a cycle that carries a reference code |
| wsel | input | SELW | Weight index for the read port |
| corr_out | output | OUT_W | Corrected signed code |
| wout | output | WW | Selected weight, signed fixed point |

## Verification
The bench tracks the weights in its own model while it mixes random decisions in {-1,0,+1} with random raw codes, and it compares every corrected code and every read weight. Stretches with the strobe every fourth cycle test the update timing and alignment. Stretches with freeze, or with no strobe, test that the weights hold while correction goes on. A directed all-positive sample with a full-scale raw code drives the output into saturation. A long run against a reference that carries a known memory term shows that the previous-decision weights move off zero and that all weights settle near the true values. That run tells a correct regressor pairing apart from a swapped one.

// File: rtl/lms_memcorr.sv
module lms_memcorr #(
  parameter int L       = 2,
  parameter int DW      = 2,
  parameter int RAW_W   = 8,
  parameter int OUT_W   = 10,
  parameter int WW      = 20,
  parameter int FRAC    = 8,
  parameter int MU_SH   = 4,
  parameter int REF_LAT = 3,
  localparam int NW     = 2 * L,
  localparam int SELW   = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    freeze,
  input  logic [L*DW-1:0]         dec_in,
  input  logic [RAW_W-1:0]        raw_in,
  input  logic signed [OUT_W-1:0] ref_in,
  input  logic                    ref_valid,
  input  logic [SELW-1:0]         wsel,
  output logic signed [OUT_W-1:0] corr_out,
  output logic signed [WW-1:0]    wout
);

  localparam int SW = WW + DW + SELW + 2;
  localparam int XW = WW + OUT_W + DW + FRAC + 2;
  localparam int RW = NW * DW;
  localparam logic signed [SW-1:0] OMAX = SW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] OMIN = SW'(-(64'sd1 <<< (OUT_W - 1)));
  localparam logic signed [XW-1:0] WMAX = XW'((64'sd1 <<< (WW - 1)) - 64'sd1);
  localparam logic signed [XW-1:0] WMIN = XW'(-(64'sd1 <<< (WW - 1)));

  function automatic logic signed [WW-1:0] nominal(input int j);
    if (j % 2 == 1) return '0;
    return WW'(64'sd1 <<< (FRAC + RAW_W + L - 2 - j / 2));
  endfunction

  logic signed [WW-1:0]    w     [NW];
  logic signed [WW-1:0]    wnext [NW];
  logic [L*DW-1:0]         dprev;
  logic [RW-1:0]           rg;
  logic signed [SW-1:0]    acc;
  logic signed [SW-1:0]    accq;
  logic signed [SW-1:0]    csum;
  logic signed [OUT_W-1:0] csat;
  logic signed [OUT_W-1:0] hc [REF_LAT];
  logic [RW-1:0]           hd [REF_LAT];
  logic signed [OUT_W:0]   err;
  logic [NW*WW-1:0]        wflat;

  always_comb begin
    for (int s = 0; s < L; s++) begin
      rg[2*s*DW +: DW]     = dec_in[s*DW +: DW];
      rg[(2*s+1)*DW +: DW] = dprev[s*DW +: DW];
    end
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < NW; j++)
      acc = acc + SW'(w[j]) * SW'($signed(rg[j*DW +: DW]));
  end

  assign accq = acc >>> FRAC;
  assign csum = accq + SW'($signed({1'b0, raw_in}));
  assign csat = (csum > OMAX) ? OUT_W'(OMAX) :
                (csum < OMIN) ? OUT_W'(OMIN) : OUT_W'(csum);

  assign err = (OUT_W+1)'(ref_in) - (OUT_W+1)'(hc[REF_LAT-1]);

  always_comb begin
    logic signed [XW-1:0] prod;
    logic signed [XW-1:0] stp;
    logic signed [XW-1:0] sumv;
    for (int j = 0; j < NW; j++) begin
      prod = XW'(err) * XW'($signed(hd[REF_LAT-1][j*DW +: DW]));
      stp  = (prod <<< FRAC) >>> MU_SH;
      sumv = XW'(w[j]) + stp;
      wnext[j] = (sumv > WMAX) ? WW'(WMAX) :
                 (sumv < WMIN) ? WW'(WMIN) : WW'(sumv);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NW; j++) w[j] <= nominal(j);
      dprev    <= '0;
      corr_out <= '0;
      for (int k = 0; k < REF_LAT; k++) begin
        hc[k] <= '0;
        hd[k] <= '0;
      end
    end else begin
      if (ref_valid && !freeze)
        for (int j = 0; j < NW; j++) w[j] <= wnext[j];
      dprev    <= dec_in;
      corr_out <= csat;
      hc[0]    <= csat;
      hd[0]    <= rg;
      for (int k = 1; k < REF_LAT; k++) begin
        hc[k] <= hc[k-1];
        hd[k] <= hd[k-1];
      end
    end
  end

  assign wout = (int'(wsel) < NW) ? w[wsel] : '0;

  for (genvar j = 0; j < NW; j++) begin : g_flat
    assign wflat[j*WW +: WW] = w[j];
  end

endmodule

module lms_memcorr_chk #(
  parameter int L     = 2,
  parameter int DW    = 2,
  parameter int RAW_W = 8,
  parameter int WW    = 20,
  parameter int FRAC  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              freeze,
  input logic              ref_valid,
  input logic [L*DW-1:0]   dec_in,
  input logic [L*DW-1:0]   dprev,
  input logic [2*L*WW-1:0] wflat
);

  function automatic logic [2*L*WW-1:0] start_set();
    logic [2*L*WW-1:0] v;
    v = '0;
    for (int s = 0; s < L; s++)
      v[2*s*WW +: WW] = WW'(64'sd1 <<< (FRAC + RAW_W + L - 2 - s));
    return v;
  endfunction

  assert_reset_nominal_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> wflat == start_set());

  assert_prev_delay_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> dprev == $past(dec_in));

  assert_noref_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !ref_valid |=> $stable(wflat));

  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(wflat));

endmodule

bind lms_memcorr lms_memcorr_chk #(
  .L(L), .DW(DW), .RAW_W(RAW_W), .WW(WW), .FRAC(FRAC)
) u_chk (
  .clk(clk), .rst(rst), .freeze(freeze), .ref_valid(ref_valid),
  .dec_in(dec_in), .dprev(dprev), .wflat(wflat)
);

// File: tb/lms_memcorr_test.sv
`timescale 1ns/1ps
module lms_memcorr_test;
  localparam int L = 2, DW = 2, RAW_W = 8, OUT_W = 10, WW = 20;
  localparam int FRAC = 8, MU_SH = 4, REF_LAT = 3, NW = 2 * L, SELW = 2;
  localparam int DEC_M = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, freeze, ref_valid;
  logic [L*DW-1:0] dec_in;
  logic [RAW_W-1:0] raw_in;
  logic signed [OUT_W-1:0] ref_in, corr_out;
  logic [SELW-1:0] wsel;
  logic signed [WW-1:0] wout;

  lms_memcorr #(.L(L), .DW(DW), .RAW_W(RAW_W), .OUT_W(OUT_W), .WW(WW),
                .FRAC(FRAC), .MU_SH(MU_SH), .REF_LAT(REF_LAT)) uut (
    .clk(clk), .rst(rst), .freeze(freeze), .dec_in(dec_in), .raw_in(raw_in),
    .ref_in(ref_in), .ref_valid(ref_valid), .wsel(wsel),
    .corr_out(corr_out), .wout(wout));

  int checks = 0, errors = 0, cyc = 0;
  longint mw[NW], tw[NW], mhc[REF_LAT], tq[REF_LAT];
  int mhd[REF_LAT][NW];
  int mprev[L];

  function automatic longint clampv(longint v, int bits);
    longint mx, mn;
    mx = (64'sd1 <<< (bits - 1)) - 1;
    mn = -(64'sd1 <<< (bits - 1));
    return (v > mx) ? mx : (v < mn) ? mn : v;
  endfunction

  function automatic longint nomw(int j);
    if (j % 2 == 1) return 0;
    return 64'sd1 <<< (FRAC + RAW_W + L - 2 - j / 2);
  endfunction

  function automatic longint corr_of(longint wa[NW], int rv[NW], int raw);
    longint a;
    a = 0;
    for (int j = 0; j < NW; j++) a += wa[j] * rv[j];
    return clampv((a >>> FRAC) + raw, OUT_W);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; freeze = 1'b0; ref_valid = 1'b0; dec_in = '0; raw_in = '0;
    ref_in = '0; wsel = '0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    for (int j = 0; j < NW; j++) mw[j] = nomw(j);
    for (int s = 0; s < L; s++) mprev[s] = 0;
    for (int k = 0; k < REF_LAT; k++) begin
      mhc[k] = 0; tq[k] = 0;
      for (int j = 0; j < NW; j++) mhd[k][j] = 0;
    end
    check("R1 reset output", corr_out, 0);
    for (int j = 0; j < NW; j++) begin
      wsel = SELW'(j); #1;
      check("R1 R8 reset weight", wout, nomw(j));
    end
    rst = 1'b0;
  endtask

  task automatic step(int d0, int d1, int raw, bit refv, bit frz, int sel, string tag);
    int d[L];
    int rv[NW];
    longint ec, et, e;
    d[0] = d0; d[1] = d1;
    for (int s = 0; s < L; s++) begin
      rv[2*s] = d[s]; rv[2*s+1] = mprev[s];
    end
    ec = corr_of(mw, rv, raw);
    et = corr_of(tw, rv, raw);
    dec_in = {DW'(d1), DW'(d0)};
    raw_in = RAW_W'(raw);
    ref_valid = refv; freeze = frz; wsel = SELW'(sel);
    ref_in = OUT_W'(tq[REF_LAT-1]);
    if (refv && !frz) begin
      e = tq[REF_LAT-1] - mhc[REF_LAT-1];
      for (int j = 0; j < NW; j++)
        mw[j] = clampv(mw[j] + (((e * mhd[REF_LAT-1][j]) <<< FRAC) >>> MU_SH), WW);
    end
    for (int k = REF_LAT - 1; k > 0; k--) begin
      mhc[k] = mhc[k-1]; tq[k] = tq[k-1];
      for (int j = 0; j < NW; j++) mhd[k][j] = mhd[k-1][j];
    end
    mhc[0] = ec; tq[0] = et;
    for (int j = 0; j < NW; j++) mhd[0][j] = rv[j];
    for (int s = 0; s < L; s++) mprev[s] = d[s];
    cyc++;
    @(posedge clk); @(negedge clk);
    check(tag, corr_out, ec);
    check(tag, wout, mw[sel]);
  endtask

  function automatic int rd();
    return int'($urandom_range(0, 2)) - 1;
  endfunction

  task automatic run(int n, int rawmax, int mode, bit frz, string tag);
    for (int i = 0; i < n; i++)
      step(rd(), rd(), int'($urandom_range(0, rawmax)),
           (mode == 1) && (cyc % DEC_M == 0), frz,
           int'($urandom_range(0, NW - 1)), tag);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250611));
    tw[0] = nomw(0) + 3 * 256 + 64;
    tw[1] = -640;
    tw[2] = nomw(2) - 356;
    tw[3] = 300;
    do_reset();
    // directed: positive full-scale drives saturation
    step(1, 1, 255, 1'b0, 1'b0, 0, "R7 R2 sat");
    check("R7 saturated value", corr_out, 511);
    step(-1, -1, 0, 1'b0, 1'b0, 2, "R2 R3 negative");
    check("R2 negative value", corr_out, -384);
    step(0, 1, 17, 1'b0, 1'b0, 1, "R2 mid");
    check("R2 mid value", corr_out, 145);
    run(200, 255, 0, 1'b0, "R5 no strobe");
    run(400, 255, 1, 1'b0, "R4 adapt");
    run(200, 255, 1, 1'b1, "R6 freeze");
    run(100, 255, 0, 1'b0, "R5 hold");
    run(8000, 120, 1, 1'b0, "R2 R3 R4 track");
    for (int j = 0; j < NW; j++) begin
      wsel = SELW'(j); #1;
      checks++;
      if ((wout - tw[j] > 256) || (tw[j] - wout > 256)) begin
        errors++;
        $display("FAIL R9 weight %0d actual %0d expected %0d", j, wout, tw[j]);
      end
    end
    do_reset();
    run(40, 255, 1, 1'b0, "R4 after reset");
    finish_run();
  end
endmodule